// File: doc/BRIEF.md
# Programmable Per-Channel Gamma Correction Stage

This block sits in a display pixel pipeline and applies gamma correction to each 24-bit pixel, one colour component at a time. It keeps three lookup tables of 256 entries of 8 bits. The first table maps the red (or Y) component, the second maps green (or U) and the third maps blue (or V). When correction is enabled and the table memory is powered and selected, every component of an incoming pixel indexes its own table and the looked-up value replaces it. Otherwise the pixel goes through unchanged. Both paths take exactly one clock, and a valid flag travels with the data.

Software reaches the tables indirectly through a small synchronous register port. It first places an entry value in a staging register. It then writes a control word whose command field, table-select field and index field say what to do with that value. A control write can store an entry, read an entry back into a result register, or start a fill of one table with an identity ramp. The ramp fill runs for 256 cycles, and a busy flag is raised while it runs. Power-down and chip-select bits in a memory configuration register gate all table access.

Top module: `gamma_lut_stage`

## Requirements
- R1: With correction active, pixel bits 23:16 are replaced by table 0 at that index, bits 15:8 by table 1, and bits 7:0 by table 2. Each table has 256 entries of 8 bits.
- R2: A control word is decoded as follows. Bits 15:14 hold the command: 0 read, 2 write, 3 ramp fill, and 1 does nothing. Bits 11:8 select the table (0, 1 or 2). Bits 7:0 give the entry index.
- R3: Register address 0 holds the staging value in bits 7:0. A write to address 1 with the write command stores that value into the selected entry. A pixel arriving in the next cycle already sees the new value.
- R4: Address 2 bit 0 is the correction enable. While it is 0, every pixel leaves unchanged.
- R5: Address 3 bit 0 is chip-select and bit 1 is power-down. After reset, power-down is 1 and chip-select is 0. The tables are active only with chip-select 1 and power-down 0. While inactive, write and ramp commands are ignored and pixels bypass the tables.
- R6: A read command loads the addressed entry into the result register, which is read at address 4 in bits 7:0, at the clock edge that takes the control write. If the tables are inactive, it loads 0 instead.
- R7: A ramp command sets every entry i of the selected table to i, one entry per cycle. The busy output is high for exactly 256 cycles, starting the cycle after the command. While busy, pixels bypass the tables and every control write is ignored.
- R8: pix_valid_out and pix_out follow pix_valid_in and pix_in with a latency of exactly one clock, in both lookup and bypass.
- R9: A table select of 3 to 15 makes write and ramp commands no-ops, and makes a read command load 0.
- R10: During and right after reset, pix_valid_out, pix_out, busy and the result register are 0. Address 3 reads back 2, and addresses 0 and 2 read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_in | input | 24 | Input pixel, component 0 in bits 23:16 |
| pix_valid_out | output | 1 | Output pixel valid |
| pix_out | output | 24 | Corrected or bypassed pixel |
| init_busy | output | 1 | Ramp fill in progress |

## Verification
A changing pixel stream runs through the block while the tables are loaded with three different functions: an inverting table, an XOR table and a multiply table. Because each component gets a distinct mapping, a swapped table or a wrong bit slice shows up as a mismatch. The same stream is then sent with correction disabled, with the memory powered down and during a ramp fill. These cases separate the three bypass reasons from each other and from identity tables. Register reads after writes made while powered down, while busy, with a bad select and with the no-op command show whether each of those stimuli was really ignored.

// File: rtl/glut_pkg.sv
package glut_pkg;
  localparam int COMP_W  = 8;
  localparam int COMP_N  = 3;
  localparam int SEL_W   = 4;
  localparam int OP_LSB  = 14;
  localparam int SEL_LSB = 8;

  localparam int unsigned A_STAGE  = 0;
  localparam int unsigned A_CTRL   = 1;
  localparam int unsigned A_DISP   = 2;
  localparam int unsigned A_RAMCFG = 3;
  localparam int unsigned A_RESULT = 4;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_NOP   = 2'd1,
    OP_WRITE = 2'd2,
    OP_FILL  = 2'd3
  } glut_op_e;

  typedef struct packed {
    glut_op_e           op;
    logic [SEL_W-1:0]   sel;
    logic [COMP_W-1:0]  idx;
  } glut_cmd_t;

  function automatic glut_cmd_t decode_ctrl(input logic [15:0] w);
    glut_cmd_t c;
    c.op  = glut_op_e'(w[OP_LSB +: 2]);
    c.sel = w[SEL_LSB +: SEL_W];
    c.idx = w[COMP_W-1:0];
    return c;
  endfunction

  function automatic logic sel_is_table(input logic [SEL_W-1:0] s, input int n);
    return int'(s) < n;
  endfunction
endpackage

// File: rtl/glut_regs.sv
module glut_regs
  import glut_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  input  logic          busy,
  input  logic          rd_load,
  input  logic [CW-1:0] rd_value,
  output logic [CW-1:0] stage_q,
  output logic          gamma_en,
  output logic          ram_cs,
  output logic          ram_pd,
  output logic          ctrl_fire,
  output glut_cmd_t     cmd,
  output logic [CW-1:0] rd_data_q,
  output logic [DW-1:0] reg_rdata
);
  logic hit_stage, hit_ctrl, hit_disp, hit_cfg;

  assign hit_stage = reg_addr == AW'(A_STAGE);
  assign hit_ctrl  = reg_addr == AW'(A_CTRL);
  assign hit_disp  = reg_addr == AW'(A_DISP);
  assign hit_cfg   = reg_addr == AW'(A_RAMCFG);

  assign cmd       = decode_ctrl(reg_wdata);
  assign ctrl_fire = reg_we && hit_ctrl && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q   <= '0;
      gamma_en  <= 1'b0;
      ram_cs    <= 1'b0;
      ram_pd    <= 1'b1;
      rd_data_q <= '0;
    end else begin
      if (reg_we && hit_stage) stage_q  <= reg_wdata[CW-1:0];
      if (reg_we && hit_disp)  gamma_en <= reg_wdata[0];
      if (reg_we && hit_cfg) begin
        ram_cs <= reg_wdata[0];
        ram_pd <= reg_wdata[1];
      end
      if (rd_load) rd_data_q <= rd_value;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(A_STAGE):  reg_rdata[CW-1:0] = stage_q;
      AW'(A_DISP):   reg_rdata[0]      = gamma_en;
      AW'(A_RAMCFG): reg_rdata[1:0]    = {ram_pd, ram_cs};
      AW'(A_RESULT): reg_rdata[CW-1:0] = rd_data_q;
      default:       reg_rdata         = '0;
    endcase
  end
endmodule

// File: rtl/glut_fill_seq.sv
module glut_fill_seq #(
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] sel_in,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic [SW-1:0] sel
);
  logic last;
  assign last = cnt == {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sel  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      sel  <= sel_in;
    end
  end
endmodule

// File: rtl/glut_table.sv
module glut_table #(
  parameter int CW    = 8,
  parameter int DEPTH = 1 << CW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] px_addr,
  output logic [CW-1:0] px_data,
  input  logic [CW-1:0] sw_addr,
  output logic [CW-1:0] sw_data
);
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign px_data = mem[px_addr];
  assign sw_data = mem[sw_addr];
endmodule

// File: rtl/glut_pixel_path.sv
module glut_pixel_path #(
  parameter int CW  = 8,
  parameter int NCH = 3,
  localparam int PW = CW * NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [PW-1:0] pix_in,
  input  logic [PW-1:0] mapped,
  input  logic          use_lut,
  output logic          valid_out,
  output logic [PW-1:0] pix_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      pix_out   <= '0;
    end else begin
      valid_out <= valid_in;
      pix_out   <= use_lut ? mapped : pix_in;
    end
  end
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
  import glut_pkg::*;
#(
  parameter int CW  = COMP_W,
  parameter int NCH = COMP_N,
  parameter int AW  = 3,
  parameter int DW  = 16,
  localparam int PW    = CW * NCH,
  localparam int DEPTH = 1 << CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pix_valid_in,
  input  logic [PW-1:0] pix_in,
  output logic          pix_valid_out,
  output logic [PW-1:0] pix_out,
  output logic          init_busy
);
  logic [CW-1:0]    stage_q, rd_data_q, rd_value, fill_cnt;
  logic [SEL_W-1:0] fill_sel;
  logic             gamma_en, ram_cs, ram_pd, ram_on, ctrl_fire;
  logic             sel_ok, wr_fire, fill_fire, rd_fire, use_lut;
  glut_cmd_t        cmd;
  logic [PW-1:0]    mapped;
  logic [CW-1:0]    tab_rd [NCH];

  glut_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .busy(init_busy), .rd_load(rd_fire),
    .rd_value(rd_value), .stage_q(stage_q), .gamma_en(gamma_en),
    .ram_cs(ram_cs), .ram_pd(ram_pd), .ctrl_fire(ctrl_fire), .cmd(cmd),
    .rd_data_q(rd_data_q), .reg_rdata(reg_rdata)
  );

  assign ram_on    = ram_cs && !ram_pd;
  assign sel_ok    = sel_is_table(cmd.sel, NCH);
  assign wr_fire   = ctrl_fire && (cmd.op == OP_WRITE) && sel_ok && ram_on;
  assign fill_fire = ctrl_fire && (cmd.op == OP_FILL) && sel_ok && ram_on;
  assign rd_fire   = ctrl_fire && (cmd.op == OP_READ);
  assign use_lut   = gamma_en && ram_on && !init_busy;

  glut_fill_seq #(.CW(CW), .SW(SEL_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(fill_fire), .sel_in(cmd.sel),
    .busy(init_busy), .cnt(fill_cnt), .sel(fill_sel)
  );

  for (genvar t = 0; t < NCH; t++) begin : g_tab
    localparam int LSB = (NCH - 1 - t) * CW;
    logic          we_t;
    logic [CW-1:0] waddr_t, wdata_t;

    assign we_t    = (wr_fire && cmd.sel == SEL_W'(t)) ||
                     (init_busy && fill_sel == SEL_W'(t));
    assign waddr_t = init_busy ? fill_cnt : cmd.idx;
    assign wdata_t = init_busy ? fill_cnt : stage_q;

    glut_table #(.CW(CW), .DEPTH(DEPTH)) u_tab (
      .clk(clk), .we(we_t), .waddr(waddr_t), .wdata(wdata_t),
      .px_addr(pix_in[LSB +: CW]), .px_data(mapped[LSB +: CW]),
      .sw_addr(cmd.idx), .sw_data(tab_rd[t])
    );
  end

  always_comb begin
    rd_value = '0;
    for (int t = 0; t < NCH; t++) begin
      if (cmd.sel == SEL_W'(t)) rd_value = tab_rd[t];
    end
    if (!(sel_ok && ram_on)) rd_value = '0;
  end

  glut_pixel_path #(.CW(CW), .NCH(NCH)) u_pix (
    .clk(clk), .rst_n(rst_n), .valid_in(pix_valid_in), .pix_in(pix_in),
    .mapped(mapped), .use_lut(use_lut), .valid_out(pix_valid_out),
    .pix_out(pix_out)
  );
endmodule

// File: rtl/glut_checker.sv
module glut_checker #(
  parameter int CW  = 8,
  parameter int NCH = 3,
  parameter int AW  = 3,
  parameter int DW  = 16,
  localparam int PW = CW * NCH
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic          pix_valid_in,
  input logic [PW-1:0] pix_in,
  input logic          pix_valid_out,
  input logic [PW-1:0] pix_out,
  input logic          init_busy,
  input logic          gamma_en,
  input logic          ram_pd,
  input logic          ctrl_fire,
  input logic          wr_fire,
  input logic          fill_fire,
  input logic [CW-1:0] rd_data_q
);
  logic [CW+1:0] busy_run;
  logic          ctrl_wr;

  assign ctrl_wr = reg_we && reg_addr == AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= '0;
    else        busy_run <= init_busy ? busy_run + 1'b1 : '0;
  end

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_in |=> pix_valid_out);
  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_in |=> !pix_valid_out);
  assert_bypass_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gamma_en |=> pix_out == $past(pix_in));
  assert_bypass_pd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_pd |=> pix_out == $past(pix_in));
  assert_bypass_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |=> pix_out == $past(pix_in));
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_busy) |-> $past(fill_fire));
  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> busy_run == (CW+2)'(1 << CW));
  assert_busy_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= (CW+2)'(1 << CW));
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !ctrl_fire);
  assert_pd_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_pd && ctrl_wr) |-> !wr_fire && !fill_fire);
  assert_badsel_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_fire && reg_wdata[15:14] == 2'd0 && int'(reg_wdata[11:8]) >= NCH)
      |=> rd_data_q == '0);
endmodule

bind gamma_lut_stage glut_checker #(.CW(CW), .NCH(NCH), .AW(AW), .DW(DW)) u_glut_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .pix_valid_in(pix_valid_in), .pix_in(pix_in),
  .pix_valid_out(pix_valid_out), .pix_out(pix_out), .init_busy(init_busy),
  .gamma_en(gamma_en), .ram_pd(ram_pd), .ctrl_fire(ctrl_fire),
  .wr_fire(wr_fire), .fill_fire(fill_fire), .rd_data_q(rd_data_q)
);

// File: tb/test_gamma_lut_stage.sv
module test_gamma_lut_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = 3'd7;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pix_valid_in = 1'b0;
  logic [23:0] pix_in = '0;
  logic        pix_valid_out;
  logic [23:0] pix_out;
  logic        init_busy;

  int n_chk = 0, n_fail = 0, cyc = 0, pcnt = 0;
  bit pix_run = 1'b0;

  gamma_lut_stage i_gamma_lut_stage (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid_in(pix_valid_in),
    .pix_in(pix_in), .pix_valid_out(pix_valid_out), .pix_out(pix_out),
    .init_busy(init_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_tab [3][256];
  int m_stage, m_en, m_cs, m_pd, m_rd, m_busy, m_icnt, m_isel;
  int m_vld, m_pix, m_known;
  string m_mode;
  int pre_busy, act, op, sel, idx, v, start_fill;

  function automatic int tab_fn(int t, int i);
    case (t)
      0: return 255 - i;
      1: return i ^ 8'h5A;
      default: return (i * 7) & 255;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act_v, int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  initial begin
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 256; i++) m_tab[t][i] = -1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_en = 0; m_cs = 0; m_pd = 1; m_rd = 0;
      m_busy = 0; m_icnt = 0; m_isel = 0; m_vld = 0; m_pix = 0; m_known = 1;
      m_mode = "R10";
    end else begin
      pre_busy = m_busy;
      act = (m_cs == 1 && m_pd == 0) ? 1 : 0;
      m_vld = pix_valid_in;
      m_known = 1;
      if (m_en == 1 && act == 1 && pre_busy == 0) begin
        m_mode = "R1";
        m_pix = 0;
        for (int c = 0; c < 3; c++) begin
          v = m_tab[c][(pix_in >> (16 - 8*c)) & 255];
          if (v < 0) m_known = 0;
          m_pix = m_pix | ((v & 255) << (16 - 8*c));
        end
      end else begin
        m_mode = (m_en == 0) ? "R4" : (act == 0) ? "R5" : "R7";
        m_pix = pix_in;
      end
      start_fill = 0;
      if (reg_we && reg_addr == 3'd1 && pre_busy == 0) begin
        op = reg_wdata[15:14]; sel = reg_wdata[11:8]; idx = reg_wdata[7:0];
        if (op == 0) m_rd = (sel < 3 && act == 1) ? m_tab[sel][idx] : 0;
        if (op == 2 && sel < 3 && act == 1) m_tab[sel][idx] = m_stage;
        if (op == 3 && sel < 3 && act == 1) start_fill = 1;
      end
      if (pre_busy == 1) begin
        m_tab[m_isel][m_icnt] = m_icnt;
        if (m_icnt == 255) m_busy = 0; else m_icnt++;
      end
      if (start_fill == 1) begin m_busy = 1; m_icnt = 0; m_isel = sel; end
      if (reg_we && reg_addr == 3'd0) m_stage = reg_wdata[7:0];
      if (reg_we && reg_addr == 3'd2) m_en = reg_wdata[0];
      if (reg_we && reg_addr == 3'd3) begin m_cs = reg_wdata[0]; m_pd = reg_wdata[1]; end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(init_busy == m_busy[0], "R7", "busy", init_busy, m_busy);
      chk(pix_valid_out == m_vld[0], "R8", "valid_out", pix_valid_out, m_vld);
      if (m_vld == 1 && m_known == 1)
        chk(pix_out == m_pix[23:0], m_mode, "pix_out", pix_out, m_pix);
    end
  end

  // pixel stream driver
  always @(negedge clk) begin
    if (pix_run) begin
      pcnt++;
      pix_in = {8'(pcnt * 37), 8'(pcnt * 91 + 5), 8'(pcnt * 13 + 200)};
      pix_valid_in = (pcnt % 5) != 3;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic reg_wr(int a, int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 16'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd7;
  endtask

  task automatic ctrl(int o, int s, int i);
    reg_wr(1, (o << 14) | (s << 8) | i);
  endtask

  task automatic reg_rd(int a, int exp_v, string req, string what);
    @(negedge clk);
    reg_addr = 3'(a);
    #(CLK_PERIOD/4);
    chk(reg_rdata == 16'(exp_v), req, what, reg_rdata, exp_v);
    reg_addr = 3'd7;
  endtask

  task automatic read_entry(int s, int i, int exp_v, string req);
    ctrl(0, s, i);
    reg_rd(4, exp_v, req, "result reg");
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && init_busy; k++) @(negedge clk);
  endtask

  initial begin
    pix_run = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(pix_valid_out == 1'b0, "R10", "valid in reset", pix_valid_out, 0);
    chk(pix_out == '0, "R10", "pix in reset", pix_out, 0);
    chk(init_busy == 1'b0, "R10", "busy in reset", init_busy, 0);
    reg_rd(4, 0, "R10", "result reset");
    reg_rd(3, 2, "R10", "ramcfg reset");
    reg_rd(2, 0, "R10", "enable reset");
    reg_rd(0, 0, "R10", "stage reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R5: ramp command while powered down is ignored
    ctrl(3, 0, 0);
    @(negedge clk);
    chk(init_busy == 1'b0, "R5", "fill while pd", init_busy, 0);
    reg_wr(3, 1);
    reg_rd(3, 1, "R5", "ramcfg readback");
    reg_wr(2, 1);
    // R7: identity fill of each table, with a write issued while busy
    ctrl(3, 0, 0);
    reg_wr(0, 8'h99);
    ctrl(2, 1, 7);
    ctrl(0, 1, 7);
    reg_rd(4, 0, "R7", "read ignored while busy");
    wait_idle();
    ctrl(3, 1, 0); wait_idle();
    ctrl(3, 2, 0); wait_idle();
    read_entry(1, 7, 7, "R7");
    read_entry(0, 255, 255, "R7");
    read_entry(2, 128, 128, "R7");
    // R3: load distinct functions into all tables
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 256; i++) begin
        reg_wr(0, tab_fn(t, i));
        ctrl(2, t, i);
      end
    read_entry(0, 10, tab_fn(0, 10), "R3");
    read_entry(1, 200, tab_fn(1, 200), "R3");
    read_entry(2, 33, tab_fn(2, 33), "R6");
    repeat (40) @(negedge clk);            // R1 lookup stream
    // R4: correction disabled
    reg_wr(2, 0);
    repeat (30) @(negedge clk);
    reg_wr(2, 1);
    repeat (10) @(negedge clk);
    // R5: powered down: bypass, writes ignored, reads return 0
    reg_wr(3, 3);
    repeat (20) @(negedge clk);
    reg_wr(0, 8'h00);
    ctrl(2, 0, 10);
    read_entry(0, 20, 0, "R5");
    reg_wr(3, 1);
    read_entry(0, 10, tab_fn(0, 10), "R5");
    // R9: bad table selects
    reg_wr(0, 8'h11);
    ctrl(2, 3, 4);
    ctrl(3, 15, 0);
    @(negedge clk);
    chk(init_busy == 1'b0, "R9", "fill bad select", init_busy, 0);
    read_entry(3, 4, 0, "R9");
    read_entry(2, 4, tab_fn(2, 4), "R9");
    read_entry(15, 4, 0, "R9");
    // R2: command code 1 is a no-op
    read_entry(1, 9, tab_fn(1, 9), "R2");
    ctrl(1, 0, 20);
    reg_rd(4, tab_fn(1, 9), "R2", "nop keeps result");
    read_entry(0, 20, tab_fn(0, 20), "R2");
    // R3: write takes effect on the next pixel
    reg_wr(0, 8'hC3);
    ctrl(2, 2, 77);
    read_entry(2, 77, 8'hC3, "R3");
    repeat (20) @(negedge clk);
    // R7: refill table 2 during live stream
    ctrl(3, 2, 0);
    @(negedge clk);
    chk(init_busy == 1'b1, "R7", "busy after fill", init_busy, 1);
    wait_idle();
    read_entry(2, 200, 200, "R7");
    read_entry(0, 200, tab_fn(0, 200), "R7");
    repeat (30) @(negedge clk);
    pix_run = 1'b0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule